// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a simple synchronous request port and an external asynchronous static RAM. The RAM is 1M words of 32 bits. It has one active-low select per byte lane, plus one shared active-low write strobe and one shared active-low output strobe. An internal client raises a request with a word address, write data, a per-lane mask and a read/write flag. The controller turns that request into a timed strobe sequence. Byte-granular writes and reads come from driving low only the lane selects whose mask bit is set. No separate byte-enable pins are used.

The RAM commits a write only while a select and the write strobe overlap. Whichever strobe rises first ends the write. The controller therefore raises the write strobe first and keeps the address, the selects and the driven data unchanged for a hold cycle afterwards. Every analogue timing figure is a parameter in nanoseconds, which is rounded up to whole clock cycles. After every read, the controller leaves the shared data bus idle for a turnaround window so that the RAM outputs can release before the controller drives the bus again. All memory-side strobes come straight from flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: In and after reset, all four lane selects, the write strobe and the output strobe are high, the data drivers are off, `rdy` is high and `rd_data` is zero.
- R2: A request is taken only on a clock edge where `req` and `rdy` are both high. `rdy` then stays low until the access ends, and a `req` pulse that starts and ends while `rdy` is low has no effect on memory contents.
- R3: During a write, the select of lane i (data bits 8i+7..8i) is low exactly when mask bit i is set. Only those lanes of the addressed word change.
- R4: On the cycle before the write strobe falls, the address, the selects and the driven data already hold their final values with the drivers on, for at least SETUP_CYC = max(1, ceil(T_AS_NS/T_CLK_NS)) cycles.
- R5: The write strobe stays low for exactly WE_CYC = max(1, ceil(max(T_WP_NS, T_DW_NS)/T_CLK_NS)) cycles, and the output strobe stays high throughout the write.
- R6: For one cycle after the write strobe rises, the address, the selects and the driven data are unchanged and the drivers stay on.
- R7: A write keeps `rdy` low for SETUP_CYC + WE_CYC + 1 cycles.
- R8: During a read, the output strobe is low for RD_CYC = max(1, ceil(T_AA_NS/T_CLK_NS)) cycles, the write strobe is high, the selects follow the mask as in R3, and the drivers are off.
- R9: Read data is captured on the last cycle of the output-strobe window. Only lanes whose mask bit is set are updated in `rd_data`, and the other lanes keep their previous value.
- R10: After a read, at least TURN_CYC = max(1, ceil(T_HZ_NS/T_CLK_NS)) cycles pass with all strobes high and the drivers off before `rdy` returns. A read keeps `rdy` low for RD_CYC + TURN_CYC cycles.
- R11: The data drivers are never on while the output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte lane mask, bit i = lane i |
| rdy | output | 1 | Idle; a request is taken when high |
| rd_data | output | 32 | Registered read data |
| mem_addr | output | 20 | RAM address |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 32 | Data to drive onto the RAM bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 32 | Data sampled from the RAM bus |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is still in progress. `rdy` gates the request, so a normal client never produces it. The bench therefore injects a write pulse in the middle of a busy window, with an address and data of its own, and later reads that address back to show the word is untouched. A second hard case is a write that directly follows a read. This is the only point where the turnaround matters. Constrained random sequences of mixed reads and writes over a small aliased address range produce many such pairs, including empty and full lane masks. Unselected lanes on the bus carry a marker value, so any stray lane update shows up in the read data.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int T_CLK_NS = 4,
  parameter int T_AS_NS = 1,
  parameter int T_WP_NS = 10,
  parameter int T_DW_NS = 7,
  parameter int T_AA_NS = 12,
  parameter int T_HZ_NS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_mask,
  output logic              rdy,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     mem_addr,
  output logic [DW/8-1:0]   mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);
  localparam int LANES = DW / 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + T_CLK_NS - 1) / T_CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_CYC = cyc(T_AS_NS);
  localparam int WE_CYC    = cyc((T_WP_NS > T_DW_NS) ? T_WP_NS : T_DW_NS);
  localparam int RD_CYC    = cyc(T_AA_NS);
  localparam int TURN_CYC  = cyc(T_HZ_NS);
  localparam int MAX_A     = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_B     = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAXC      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW        = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC, S_TURN} st_t;

  st_t             st, nxt;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic [LANES-1:0] mask_q, sel_mask;
  logic            last, take;

  assign last     = (cnt == '0);
  assign take     = (st == S_IDLE) && req && rdy;
  assign sel_mask = take ? req_mask : mask_q;

  always_comb begin
    nxt     = st;
    cnt_nxt = last ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE: if (take) begin
        nxt     = req_wr ? S_WSET : S_RACC;
        cnt_nxt = req_wr ? CW'(SETUP_CYC - 1) : CW'(RD_CYC - 1);
      end
      S_WSET: if (last) begin
        nxt     = S_WPUL;
        cnt_nxt = CW'(WE_CYC - 1);
      end
      S_WPUL: if (last) begin
        nxt     = S_WHLD;
        cnt_nxt = '0;
      end
      S_WHLD: nxt = S_IDLE;
      S_RACC: if (last) begin
        nxt     = S_TURN;
        cnt_nxt = CW'(TURN_CYC - 1);
      end
      S_TURN: if (last) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      rdy        <= 1'b1;
      mask_q     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_cs_n   <= '1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rd_data    <= '0;
    end else begin
      st        <= nxt;
      cnt       <= cnt_nxt;
      rdy       <= (nxt == S_IDLE);
      if (take) begin
        mask_q     <= req_mask;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_cs_n  <= (nxt inside {S_WSET, S_WPUL, S_WHLD, S_RACC}) ? ~sel_mask : '1;
      mem_we_n  <= (nxt != S_WPUL);
      mem_oe_n  <= (nxt != S_RACC);
      mem_dq_oe <= (nxt inside {S_WSET, S_WPUL, S_WHLD});
      if (st == S_RACC && last)
        for (int i = 0; i < LANES; i++)
          if (mask_q[i]) rd_data[8*i +: 8] <= mem_dq_in[8*i +: 8];
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int WE_CYC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            rdy,
  input logic [AW-1:0]   mem_addr,
  input logic [DW/8-1:0] mem_cs_n,
  input logic            mem_we_n,
  input logic            mem_oe_n,
  input logic [DW-1:0]   mem_dq_out,
  input logic            mem_dq_oe
);
  logic [7:0] we_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_run <= '0;
    else we_run <= mem_we_n ? 8'd0 : we_run + 8'd1;

  AST_TAKE_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && rdy) |=> !rdy); // R2
  AST_WE_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_dq_out) && $past(mem_dq_oe))); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WE_CYC[7:0])); // R5
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_dq_out) && mem_dq_oe)); // R6
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R11
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .rdy(rdy), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
  localparam int SETUP_E = 1, WE_E = 3, RD_E = 3, TURN_E = 2;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic rdy, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] rd_data, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;
  logic [3:0]  mem_cs_n;

  int checks = 0, fails = 0;
  logic [31:0] bmem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] exp_rd = '0;
  logic [3:0]  cur_mask = '0;
  logic        mon_on = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl dut_i (.*);

  function automatic logic [31:0] lanes(input logic [3:0] m);
    for (int i = 0; i < 4; i++) lanes[8*i +: 8] = {8{m[i]}};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge mem_we_n)
    if (rst_n === 1'b1)
      for (int i = 0; i < 4; i++)
        if (!mem_cs_n[i]) bmem[mem_addr[5:0]][8*i +: 8] = mem_dq_out[8*i +: 8];

  always @* begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[8*i +: 8] = (!mem_oe_n && mem_we_n && !mem_cs_n[i]) ? bmem[mem_addr[5:0]][8*i +: 8] : 8'hEE;
  end

  logic        p_we = 1, p_oe = 1;
  logic [19:0] p_addr;
  logic [3:0]  p_cs;
  logic [31:0] p_dout;
  logic        p_dqoe;
  int we_run = 0, gap = 0;
  bit gap_arm = 0;

  always @(negedge clk) if (mon_on) begin
    if (mem_dq_oe && !mem_oe_n) chk(0, "R11 drive during read", 1, 0);
    if (!mem_we_n) begin
      we_run++;
      chk(mem_oe_n && mem_cs_n == ~cur_mask, "R3 selects during write", {mem_oe_n, mem_cs_n}, {1'b1, ~cur_mask});
    end
    if (p_we && !mem_we_n)
      chk(p_addr == mem_addr && p_cs == mem_cs_n && p_dout == mem_dq_out && p_dqoe, "R4 setup", {p_addr, p_cs}, {mem_addr, mem_cs_n});
    if (!p_we && mem_we_n) begin
      chk(we_run == WE_E, "R5 we width", we_run, WE_E);
      chk(p_addr == mem_addr && p_cs == mem_cs_n && p_dout == mem_dq_out && mem_dq_oe, "R6 hold", {p_addr, p_cs}, {mem_addr, mem_cs_n});
      we_run = 0;
    end
    if (!mem_oe_n)
      chk(mem_we_n && !mem_dq_oe && mem_cs_n == ~cur_mask, "R8 read strobes", {mem_we_n, mem_dq_oe, mem_cs_n}, {2'b10, ~cur_mask});
    if (!mem_oe_n) begin gap = 0; gap_arm = 1; end
    else if (gap_arm) begin
      if (mem_dq_oe) begin chk(gap >= TURN_E, "R10 turnaround", gap, TURN_E); gap_arm = 0; end
      else gap++;
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_addr = mem_addr; p_cs = mem_cs_n;
    p_dout = mem_dq_out; p_dqoe = mem_dq_oe;
  end

  task automatic access(input bit wr, input logic [19:0] a, input logic [31:0] d, input logic [3:0] m, input bit inject);
    int busy;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m; cur_mask = m;
    @(negedge clk);
    req = 0;
    busy = 0;
    while (!rdy && busy < 50) begin
      busy++;
      if (inject && busy == 2) begin req = 1; req_wr = 1; req_addr = 20'h0003F; req_wdata = 32'hDEADBEEF; req_mask = 4'hF; end
      if (inject && busy == 3) req = 0;
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == SETUP_E + WE_E + 1, "R7 write busy", busy, SETUP_E + WE_E + 1);
      ref_mem[a[5:0]] = (ref_mem[a[5:0]] & ~lanes(m)) | (d & lanes(m));
    end else begin
      chk(busy == RD_E + TURN_E, "R10 read busy", busy, RD_E + TURN_E);
      exp_rd = (exp_rd & ~lanes(m)) | (ref_mem[a[5:0]] & lanes(m));
      chk(rd_data == exp_rd, m == 4'hF ? "R9 read data" : "R3 R9 masked read", rd_data, exp_rd);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'h5EED);
    for (int i = 0; i < 64; i++) begin bmem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && rdy && rd_data == 0,
        "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy}, {4'hF, 4'b1101});
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && rdy, "R1 after reset", mem_cs_n, 4'hF);
    mon_on = 1;

    access(1, 20'h00005, 32'h11223344, 4'hF, 0);
    access(0, 20'h00005, 0, 4'hF, 0);
    access(1, 20'h00005, 32'hAABBCCDD, 4'b0101, 0);
    access(0, 20'h00005, 0, 4'hF, 0);
    access(1, 20'h00005, 32'h99999999, 4'b0000, 0);
    access(0, 20'h00005, 0, 4'b1010, 0);
    access(1, 20'h00010, 32'hCAFEF00D, 4'hF, 1);
    access(0, 20'h0003F, 0, 4'hF, 0);
    chk(rd_data == 32'h0, "R2 busy request ignored", rd_data, 0);
    access(0, 20'h00010, 0, 4'b0110, 0);
    access(1, 20'h00010, 32'h01020304, 4'b1000, 0);

    for (int n = 0; n < 400; n++) begin
      bit wr;
      logic [19:0] a;
      wr = ($urandom % 2) == 1;
      a = {$urandom % 4, 12'h0, 6'($urandom % 64)} & 20'hFFFFF;
      access(wr, a, $urandom, 4'($urandom), 0);
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule